// File: doc/BRIEF.md
# Unified Scalable Montgomery Multiplier Array

This block computes a radix-2 Montgomery product of two operands. In prime mode it works on integers modulo an odd modulus. In binary mode it works on polynomials over GF(2) modulo a polynomial whose constant term is one. A single mode input selects the field for each operation. The caller asserts a start pulse with the operands and the modulus on parallel ports. It then waits for a one-cycle done pulse, after which the product sits on the result port. The result stays there until the next operation completes.

Inside, a short linear array of processing elements does the work. Each element keeps two words of the multiplicand and two words of the modulus in its own registers for the whole operation; these words never move between elements. The multiplier is shifted in serially, one bit per two-cycle iteration. The first cycle of an iteration forms the parity bit in the element that holds word 0. The second cycle folds the running sum, the carry vector, the selected multiplicand and the selected modulus together with one level of 4-to-2 compression. That compression is built from dual-field adder cells, and each cell drops its carry when binary mode is selected. After the last iteration, the carry-save pair is resolved word by word into a plain binary result.

The block does no final subtraction. It does not precompute Montgomery constants and does not sequence exponentiation.

Top module: `mont_unified_array`

## Requirements
- R1: In prime mode (mode input 0), with M odd, M < 2^N and Y < M, the result equals T, the value left by N radix-2 Montgomery steps on X, Y and M. T ≡ X·Y·2^-N (mod M), T < 2M, and no final subtraction is applied.
- R2: In binary mode (mode input 1), with bit 0 of M set and deg Y < deg M, the result equals the carry-free Montgomery product X·Y·x^-N mod M. Bit k of each port is the coefficient of x^k.
- R3: done_o is high for exactly one cycle. It rises after the (2N+L)-th rising edge that follows the edge which samples start_i high in idle, where L = 2·(floor(N/(2W))+1).
- R4: While an operation is running, start_i and every operand and mode input are ignored. The running operation's result and its done timing are unchanged.
- R5: res_o changes only on the edge that raises done_o, and otherwise holds its value.
- R6: After reset, done_o is 0 and res_o is 0.
- R7: In binary mode no carry is ever produced, so the stored carry vector stays all zero for the whole operation.
- R8: A zero multiplier X gives a zero result in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; sampled only when idle |
| bin_mode_i | input | 1 | 0 = prime field, 1 = binary polynomial field |
| x_i | input | N | Multiplier, consumed from bit 0 upward |
| y_i | input | N | Multiplicand |
| m_i | input | N | Modulus |
| done_o | output | 1 | One-cycle completion strobe |
| res_o | output | N+1 | Montgomery product |

## Verification
With N = 64 and W = 16, each result is due 2N + L = 134 edges after the accepting edge. The bench counts rising edges from that edge and samples done_o and res_o on the falling edge after each one. It requires done_o to appear exactly on the 135th sample, counting the accepting edge, and to be low again on the next sample. A second start issued in the middle of a run must leave both that count and the result unchanged. Several cycles after done, res_o is sampled again to confirm it has held.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_RES} mm_state_t;

  // dual-field adder cell: {carry, sum}; carry suppressed in binary mode
  function automatic logic [1:0] dfa(input logic a, input logic b, input logic c,
                                     input logic bin);
    logic s, k;
    s = a ^ b ^ c;
    k = bin ? 1'b0 : ((a & b) | (a & c) | (b & c));
    return {k, s};
  endfunction
endpackage

// File: rtl/mm_pe.sv
module mm_pe
  import mm_pkg::*;
#(
  parameter int SW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          bin_i,
  input  logic          xb_i,
  input  logic          q_i,
  input  logic          xnow_i,
  input  logic [SW-1:0] y_i,
  input  logic [SW-1:0] m_i,
  input  logic          cin_i,
  output logic          cout_o,
  input  logic          top_i,
  output logic          low_o,
  output logic          q_o,
  output logic [SW-1:0] s_o,
  output logic [SW-1:0] c_o,
  output logic [SW-1:0] m_o
);
  logic [SW-1:0] y_q, m_q, s_q, c_q, sp, cp;
  logic [SW:0]   lc;

  // single level of 4-to-2 compression over resident words
  always_comb begin
    logic [1:0] r1, r2;
    lc[0] = cin_i;
    for (int j = 0; j < SW; j++) begin
      r1 = dfa(s_q[j], c_q[j], xb_i & y_q[j], bin_i);
      r2 = dfa(r1[0], q_i & m_q[j], lc[j], bin_i);
      lc[j+1] = r1[1];
      sp[j] = r2[0];
      cp[j] = r2[1];
    end
  end

  assign cout_o = lc[SW];
  assign low_o  = sp[0];
  assign q_o    = s_q[0] ^ c_q[0] ^ (xnow_i & y_q[0]);
  assign s_o    = s_q;
  assign c_o    = c_q;
  assign m_o    = m_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q <= '0;
      m_q <= '0;
      s_q <= '0;
      c_q <= '0;
    end else if (load_i) begin
      y_q <= y_i;
      m_q <= m_i;
      s_q <= '0;
      c_q <= '0;
    end else if (step_i) begin
      s_q <= {top_i, sp[SW-1:1]};  // divide by two
      c_q <= cp;
    end
  end
endmodule

// File: rtl/mm_word_add.sv
module mm_word_add
  import mm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         bin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  always_comb begin
    logic [1:0] r;
    logic       k;
    k = cin_i;
    for (int j = 0; j < W; j++) begin
      r = dfa(a_i[j], b_i[j], k, bin_i);
      sum_o[j] = r[0];
      k = r[1];
    end
    cout_o = k;
  end
endmodule

// File: rtl/mont_unified_array.sv
module mont_unified_array
  import mm_pkg::*;
#(
  parameter int N = 1024,
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         bin_mode_i,
  input  logic [N-1:0] x_i,
  input  logic [N-1:0] y_i,
  input  logic [N-1:0] m_i,
  output logic         done_o,
  output logic [N:0]   res_o
);
  localparam int NPE = N / (2 * W) + 1;
  localparam int SW  = 2 * W;
  localparam int D   = NPE * SW;
  localparam int NWD = 2 * NPE;
  localparam int CW  = $clog2(N + 1);
  localparam int WCW = $clog2(NWD + 1);

  mm_state_t      st;
  logic           ph, bin_q, xb_q, q_q, cy_q, busy, accept, step;
  logic [CW-1:0]  bit_cnt;
  logic [WCW-1:0] wcnt;
  logic [N-1:0]   x_sh;
  logic [D-1:0]   y_pad, m_pad, s_flat, c_flat, m_flat, res_acc, res_full;
  logic [NPE:0]   lat_c, low_v;
  logic [NPE-1:0] q_v;
  logic [W-1:0]   wsum;
  logic           wcout;

  assign busy   = (st != ST_IDLE);
  assign accept = (st == ST_IDLE) && start_i;
  assign step   = (st == ST_RUN) && ph;
  assign y_pad  = {{(D-N){1'b0}}, y_i};
  assign m_pad  = {{(D-N){1'b0}}, m_i};
  assign lat_c[0]   = 1'b0;
  assign low_v[NPE] = 1'b0;

  for (genvar k = 0; k < NPE; k++) begin : g_pe
    mm_pe #(.SW(SW)) u_pe (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (accept),
      .step_i (step),
      .bin_i  (bin_q),
      .xb_i   (xb_q),
      .q_i    (q_q),
      .xnow_i (x_sh[0]),
      .y_i    (y_pad[k*SW +: SW]),
      .m_i    (m_pad[k*SW +: SW]),
      .cin_i  (lat_c[k]),
      .cout_o (lat_c[k+1]),
      .top_i  (low_v[k+1]),
      .low_o  (low_v[k]),
      .q_o    (q_v[k]),
      .s_o    (s_flat[k*SW +: SW]),
      .c_o    (c_flat[k*SW +: SW]),
      .m_o    (m_flat[k*SW +: SW])
    );
  end

  mm_word_add #(.W(W)) u_res_add (
    .a_i    (s_flat[int'(wcnt)*W +: W]),
    .b_i    (c_flat[int'(wcnt)*W +: W]),
    .cin_i  (cy_q),
    .bin_i  (bin_q),
    .sum_o  (wsum),
    .cout_o (wcout)
  );

  assign res_full = {wsum, res_acc[D-W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_IDLE;
      ph      <= 1'b0;
      bin_q   <= 1'b0;
      xb_q    <= 1'b0;
      q_q     <= 1'b0;
      cy_q    <= 1'b0;
      bit_cnt <= '0;
      wcnt    <= '0;
      x_sh    <= '0;
      res_acc <= '0;
      res_o   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        ST_IDLE: if (start_i) begin
          x_sh    <= x_i;
          bin_q   <= bin_mode_i;
          ph      <= 1'b0;
          bit_cnt <= '0;
          st      <= ST_RUN;
        end
        ST_RUN: begin
          if (!ph) begin
            xb_q <= x_sh[0];
            q_q  <= q_v[0];  // parity from word-0 element
            ph   <= 1'b1;
          end else begin
            x_sh <= x_sh >> 1;
            ph   <= 1'b0;
            if (bit_cnt == CW'(N - 1)) begin
              st   <= ST_RES;
              wcnt <= '0;
              cy_q <= 1'b0;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_RES: begin
          res_acc[int'(wcnt)*W +: W] <= wsum;
          cy_q <= wcout;
          if (wcnt == WCW'(NWD - 1)) begin
            res_o  <= res_full[N:0];
            done_o <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mont_unified_array_chk.sv
module mont_unified_array_chk #(
  parameter int N = 1024,
  parameter int W = 32,
  parameter int D = 1088
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy,
  input logic         bin_q,
  input logic         done_o,
  input logic [N:0]   res_o,
  input logic [D-1:0] c_flat,
  input logic [D-1:0] m_flat
);
  localparam int LAT = 2 * N + 2 * (N / (2 * W) + 1);
  int lat_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_cnt <= 0;
    else if (!busy && start_i) lat_cnt <= 0;
    else if (busy) lat_cnt <= lat_cnt + 1;
  end

  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> lat_cnt == LAT);
  assert_mode_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(bin_q));
  assert_result_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(res_o));
  assert_carry_free_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && bin_q) |-> c_flat == '0);
  assert_below_2m_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !bin_q) |-> res_o < {m_flat[N-1:0], 1'b0});
endmodule

bind mont_unified_array mont_unified_array_chk #(.N(N), .W(W), .D(D)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .busy   (busy),
  .bin_q  (bin_q),
  .done_o (done_o),
  .res_o  (res_o),
  .c_flat (c_flat),
  .m_flat (m_flat)
);

// File: tb/mont_unified_array_tb_top.sv
module mont_unified_array_tb_top;
  localparam int N = 64;
  localparam int W = 16;
  localparam int EXP_LAT = 2 * N + 2 * (N / (2 * W) + 1) + 1;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, bin_mode_i = 1'b0;
  logic [N-1:0] x_i = '0, y_i = '0, m_i = '0;
  logic done_o;
  logic [N:0] res_o;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  mont_unified_array #(.N(N), .W(W)) dut_i (.*);

  function automatic logic [N:0] ref_mont(input logic [N-1:0] x, y, m, input logic bin);
    logic [N+1:0] t = '0;
    for (int i = 0; i < N; i++) begin
      if (bin) begin
        if (x[i]) t = t ^ {2'b00, y};
        if (t[0]) t = t ^ {2'b00, m};
      end else begin
        if (x[i]) t = t + {2'b00, y};
        if (t[0]) t = t + {2'b00, m};
      end
      t = t >> 1;
    end
    return t[N:0];
  endfunction

  task automatic check(input string req, input logic [N:0] act, exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [N-1:0] x, y, m, input logic bin, input bit poke);
    logic [N:0] exp;
    int lat = 0;
    exp = ref_mont(x, y, m, bin);
    @(negedge clk_i);
    x_i = x; y_i = y; m_i = m; bin_mode_i = bin; start_i = 1'b1;
    while (1) begin
      @(posedge clk_i);
      @(negedge clk_i);
      start_i = 1'b0;
      lat++;
      if (poke && lat == 30) begin
        // R4: new start and operands mid-run must be ignored
        x_i = ~x; y_i = 1; m_i = 3; bin_mode_i = ~bin; start_i = 1'b1;
      end
      if (done_o || lat > EXP_LAT + 5) break;
    end
    check(poke ? "R4 latency" : "R3 latency", N'(lat), N'(EXP_LAT));
    check(poke ? "R4 result" : (bin ? "R2 result" : "R1 result"), res_o, exp);
    @(negedge clk_i);
    check("R3 single pulse", {{N{1'b0}}, done_o}, '0);
    if (poke) begin
      repeat (5) @(negedge clk_i);
      check("R5 held", res_o, exp);
    end
  endtask

  function automatic logic [N-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    logic [N-1:0] m, y;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    check("R6 done reset", {{N{1'b0}}, done_o}, '0);
    check("R6 res reset", res_o, '0);
    rst_ni = 1'b1;
    // R8 zero multiplier, both modes
    run_op('0, 64'h1234_5678_9abc_def0, 64'hffff_ffff_ffff_ffc5, 1'b0, 1'b0);
    run_op('0, 64'h0234_5678_9abc_def0, 64'h8000_0000_0000_001b, 1'b1, 1'b0);
    // directed corners
    run_op('1, 64'hffff_ffff_ffff_ffc4, 64'hffff_ffff_ffff_ffc5, 1'b0, 1'b0);
    run_op(64'd1, 64'd1, 64'h8000_0000_0000_0001, 1'b0, 1'b0);
    run_op('1, 64'h7fff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, 1'b1, 1'b0);
    for (int k = 0; k < 12; k++) begin
      m = rnd64(); m[N-1] = 1'b1; m[0] = 1'b1;
      if (k[0]) begin
        y = rnd64(); y[N-1] = 1'b0;
        run_op(rnd64(), y, m, 1'b1, k == 5);   // R2, R7
      end else begin
        y = rnd64() % m;
        run_op(rnd64(), y, m, 1'b0, k == 4);   // R1
      end
    end
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk_i);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule